// File: doc/BRIEF.md
# Multi-Mode Timer Waveform Generator

A 16-bit timer/counter that drives two waveform pins, A and B, from two compare channels. A 4-bit mode select picks one of sixteen counting schemes: free-running, clear-on-match, single-slope PWM and two kinds of dual-slope PWM. Each scheme has its own TOP value. It also has its own moment for copying newly written compare values into use and its own moment for raising the overflow flag.

The counter steps only on cycles where the `tick` input is high. An external clock-select stage supplies that tick. Software-side writes reach the counter one byte at a time, and reach the two compare registers and a period register (used as TOP by some modes). Each channel has a 2-bit output mode and a force strobe. Three sticky flags report overflow and the two compare matches. Each flag is cleared by writing a one to its bit.

Top module: `wavegen_timer16`

## Requirements
- R1: After reset the counter, all three flags and both pins are 0. The counter goes up by one on a `tick` cycle and holds its value on any cycle without `tick`.
- R2: `cnt_we[1]` loads `reg_wdata[15:8]` into the counter's high byte and `cnt_we[0]` loads `reg_wdata[7:0]` into its low byte. A counter write takes priority over `tick`, and on that cycle no match or overflow event occurs.
- R3: TOP by mode. Mode 0 and reserved mode 13 use 0xFFFF. Modes 1 and 5 use 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF. Modes 4, 9, 11 and 15 use the in-use compare A value. Modes 8, 10, 12 and 14 use the period register.
- R4: Modes 0, 4 and 12 are non-PWM modes. In mode 0 the counter wraps from 0xFFFF to 0. In modes 4 and 12 a tick at TOP returns the counter to 0. In all three modes the overflow flag (`flag_clr` bit 0) is set by a tick while the counter is at 0xFFFF.
- R5: Modes 5, 6, 7, 14 and 15 are single-slope PWM. A tick at TOP returns the counter to 0 and sets the overflow flag.
- R6: Modes 1, 2, 3, 10 and 11 are phase correct; modes 8 and 9 are phase-and-frequency correct. In these modes the counter counts up to TOP and then down to 0, turning at each end. A tick while the counter is 0 sets the overflow flag.
- R7: A compare write always lands in a buffer. In modes 0, 4 and 12 the written value is in use from the next cycle. In phase-correct modes the buffer is copied into use on a tick at TOP. In single-slope and phase-and-frequency-correct modes it is copied on a tick at 0.
- R8: A tick while the counter equals a channel's in-use compare value sets that channel's flag: A is `flag_clr` bit 1 and B is bit 2.
- R9: In non-PWM modes a match acts on the pin according to the output mode: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R10: In non-PWM modes a force strobe applies the channel's match action to the pin at once. It sets no flag and does not restart the counter. In PWM modes, and in mode 13, a force strobe has no effect.
- R11: In PWM modes, output mode 10 works as follows. Single-slope: the pin is cleared on a match and set by the tick at TOP, and the TOP action wins a tie. Dual-slope: the pin is cleared on a match while counting up and set on a match while counting down. Output mode 11 gives the inverted levels. Output modes 00 and 01 leave the pin unchanged. `wave_oe_x` is high only when the output mode is not 00 and the pin is not in PWM with output mode 01.
- R12: Writing a 1 to a `flag_clr` bit clears that flag. When a set event and a clear fall in the same cycle, the flag ends up set.
- R13: In mode 13 the counter, flags and pins all hold their values, except that counter writes still load the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from clock select |
| cnt_we | input | 2 | Byte write enables for the counter (bit 1 high byte) |
| reg_wdata | input | 16 | Shared write data |
| cmp_a_we | input | 1 | Write compare A buffer |
| cmp_b_we | input | 1 | Write compare B buffer |
| cap_we | input | 1 | Write period register |
| mode | input | 4 | Counting mode select |
| out_mode_a | input | 2 | Pin A output mode |
| out_mode_b | input | 2 | Pin B output mode |
| force_a | input | 1 | Force compare strobe A |
| force_b | input | 1 | Force compare strobe B |
| flag_clr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 A, bit2 B |
| cnt_q | output | 16 | Counter value |
| wave_a | output | 1 | Pin A level |
| wave_b | output | 1 | Pin B level |
| wave_oe_a | output | 1 | Pin A driven |
| wave_oe_b | output | 1 | Pin B driven |
| ovf_flag | output | 1 | Overflow flag |
| match_flag_a | output | 1 | Compare A flag |
| match_flag_b | output | 1 | Compare B flag |

## Verification
The bench targets the turnaround cycles of dual-slope counting. A design that gets the direction wrong shows a count that runs past TOP, or an overflow flag raised at TOP instead of at 0. Compare values are rewritten mid-period in each buffered family, so a design that copies them at the wrong end of the period puts its pin edges one period early or in the wrong half of the period. The bench also covers a compare value equal to TOP, a force strobe in CTC and in PWM modes, a flag cleared in the same cycle it is set, and a counter written above TOP in CTC mode. Wrong handling shows up as a flag raised by the force, a counter that restarts, a flag cleared when it should stay set, or a count that is wrongly restarted before it reaches 0xFFFF.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
  localparam int CNT_W     = 16;
  localparam int CNT_BYTES = CNT_W / 8;
  localparam int MODE_W    = 4;
  localparam int NUM_CH    = 2;
  localparam int NUM_FLAGS = NUM_CH + 1;

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;

  typedef enum logic [2:0] {
    FAM_NORMAL,
    FAM_CTC,
    FAM_FAST,
    FAM_PHASE,
    FAM_PFC,
    FAM_RSVD
  } fam_e;

  typedef struct packed {
    cnt_t cnt;
    logic up;
  } cstate_t;

  function automatic fam_e mode_family(input logic [MODE_W-1:0] m);
    case (m)
      4'd0:                          return FAM_NORMAL;
      4'd4, 4'd12:                   return FAM_CTC;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15: return FAM_FAST;
      4'd8, 4'd9:                    return FAM_PFC;
      4'd13:                         return FAM_RSVD;
      default:                       return FAM_PHASE;
    endcase
  endfunction

  function automatic logic fam_is_pwm(input fam_e f);
    return (f == FAM_FAST) || (f == FAM_PHASE) || (f == FAM_PFC);
  endfunction

  function automatic logic fam_dual(input fam_e f);
    return (f == FAM_PHASE) || (f == FAM_PFC);
  endfunction

  function automatic logic fam_immediate(input fam_e f);
    return (f == FAM_NORMAL) || (f == FAM_CTC);
  endfunction

  // Fixed-resolution TOP: low two mode bits give 8, 9 or 10 bits.
  function automatic cnt_t fixed_top(input logic [1:0] res);
    case (res)
      2'd1:    return cnt_t'(16'h00FF);
      2'd2:    return cnt_t'(16'h01FF);
      default: return cnt_t'(16'h03FF);
    endcase
  endfunction

  function automatic cnt_t mode_top(input logic [MODE_W-1:0] m, input cnt_t cmp_a,
                                    input cnt_t per);
    if (m == 4'd0 || m == 4'd13) return CNT_MAX;
    if (m == 4'd4) return cmp_a;
    if (!m[3]) return fixed_top(m[1:0]);
    return m[0] ? cmp_a : per;
  endfunction

  function automatic cstate_t count_step(input fam_e f, input cstate_t s, input cnt_t top);
    cstate_t n;
    n = s;
    case (f)
      FAM_NORMAL: begin
        n.cnt = s.cnt + cnt_t'(1);
        n.up  = 1'b1;
      end
      FAM_CTC, FAM_FAST: begin
        n.cnt = (s.cnt == top) ? '0 : s.cnt + cnt_t'(1);
        n.up  = 1'b1;
      end
      FAM_PHASE, FAM_PFC: begin
        if (s.up) begin
          if (s.cnt == top) begin
            if (top != '0) begin
              n.cnt = s.cnt - cnt_t'(1);
              n.up  = 1'b0;
            end
          end else begin
            n.cnt = s.cnt + cnt_t'(1);
          end
        end else if (s.cnt == '0) begin
          n.cnt = cnt_t'(1);
          n.up  = 1'b1;
        end else begin
          n.cnt = s.cnt - cnt_t'(1);
        end
      end
      default: ;
    endcase
    return n;
  endfunction

  function automatic logic ovf_point(input fam_e f, input logic at_top, input logic at_bot,
                                     input logic at_max);
    case (f)
      FAM_NORMAL, FAM_CTC: return at_max;
      FAM_FAST:            return at_top;
      FAM_PHASE, FAM_PFC:  return at_bot;
      default:             return 1'b0;
    endcase
  endfunction

  function automatic logic load_point(input fam_e f, input logic at_top, input logic at_bot);
    case (f)
      FAM_NORMAL, FAM_CTC: return 1'b1;
      FAM_PHASE:           return at_top;
      FAM_FAST, FAM_PFC:   return at_bot;
      default:             return 1'b0;
    endcase
  endfunction

  function automatic logic pin_next(input fam_e f, input logic [1:0] om, input logic p,
                                    input logic hit, input logic frc, input logic wrap,
                                    input logic up);
    logic inv;
    inv = om[0];
    if (f == FAM_RSVD || om == 2'b00) return p;
    if (!fam_is_pwm(f)) begin
      if (!(hit || frc)) return p;
      if (om == 2'b01) return ~p;
      return inv;
    end
    if (om == 2'b01) return p;
    if (f == FAM_FAST) begin
      if (wrap) return ~inv;
      if (hit) return inv;
      return p;
    end
    if (hit) return up ? inv : ~inv;
    return p;
  endfunction

  function automatic logic pin_driven(input fam_e f, input logic [1:0] om);
    return (om != 2'b00) && !(fam_is_pwm(f) && om == 2'b01);
  endfunction
endpackage

// File: rtl/wgt_top_select.sv
module wgt_top_select
  import wgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we,
  input  cnt_t              wdata,
  input  logic [MODE_W-1:0] mode,
  input  cnt_t              cmp_a_act,
  output fam_e              fam,
  output cnt_t              top_val
);
  cnt_t per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else if (cap_we) per_q <= wdata;
  end

  always_comb begin
    fam     = mode_family(mode);
    top_val = mode_top(mode, cmp_a_act, per_q);
  end

  // R3: period register feeds TOP in mode 12
  p_period_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && mode == 4'd12) ##1 (mode == 4'd12) |-> (top_val == $past(wdata)));
endmodule

// File: rtl/wgt_counter.sv
module wgt_counter
  import wgt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [CNT_BYTES-1:0] cnt_we,
  input  cnt_t                 wdata,
  input  fam_e                 fam,
  input  cnt_t                 top_val,
  output cnt_t                 cnt_q,
  output logic                 up_q,
  output logic                 adv,
  output logic                 at_top,
  output logic                 at_bot,
  output logic                 ovf_evt
);
  cnt_t    merged;
  cstate_t cur, nxt;
  logic    at_max;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = cnt_we[b] ? wdata[b*8 +: 8] : cnt_q[b*8 +: 8];
  end

  always_comb begin
    adv     = tick && (cnt_we == '0) && (fam != FAM_RSVD);
    at_top  = adv && (cnt_q == top_val);
    at_bot  = adv && (cnt_q == '0);
    at_max  = adv && (cnt_q == CNT_MAX);
    ovf_evt = ovf_point(fam, at_top, at_bot, at_max);
    cur     = '{cnt: cnt_q, up: up_q};
    nxt     = count_step(fam, cur, top_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cnt_we != '0) begin
      cnt_q <= merged;
    end else if (adv) begin
      cnt_q <= nxt.cnt;
      up_q  <= nxt.up;
    end
  end

  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && cnt_we == '0) |=> $stable(cnt_q));
  p_single_slope_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (fam == FAM_CTC || fam == FAM_FAST) && cnt_q == top_val) |=> (cnt_q == '0));
  p_dual_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fam_dual(fam) && up_q && cnt_q == top_val && top_val != '0) |=> !up_q);
  p_reserved_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fam == FAM_RSVD && cnt_we == '0) |=> $stable(cnt_q));
  p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we == '1) |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/wgt_channel.sv
module wgt_channel
  import wgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fam_e       fam,
  input  logic       adv,
  input  logic       at_top,
  input  logic       at_bot,
  input  logic       up,
  input  cnt_t       cnt,
  input  logic       cmp_we,
  input  cnt_t       wdata,
  input  logic [1:0] out_mode,
  input  logic       force_cmp,
  input  logic       flag_clr,
  output cnt_t       cmp_act,
  output logic       hit,
  output logic       pin_q,
  output logic       oe,
  output logic       flag_q
);
  cnt_t buf_q;
  cnt_t act_src;
  logic load_now;
  logic pin_d;

  always_comb begin
    hit      = adv && (cnt == cmp_act);
    load_now = load_point(fam, at_top, at_bot);
    act_src  = (fam_immediate(fam) && cmp_we) ? wdata : buf_q;
    pin_d    = pin_next(fam, out_mode, pin_q, hit, force_cmp, at_top, up);
    oe       = pin_driven(fam, out_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      cmp_act <= '0;
      pin_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cmp_we) buf_q <= wdata;
      if (load_now) cmp_act <= act_src;
      pin_q  <= pin_d;
      flag_q <= (flag_q && !flag_clr) || hit;
    end
  end

  // R10: force never raises the flag; R8: only a match does
  p_flag_from_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit));
  p_disconnected_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |=> $stable(pin_q));
  p_pwm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fam_is_pwm(fam) && !hit && !at_top) |=> $stable(pin_q));
  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag_q);
endmodule

// File: rtl/wavegen_timer16.sv
module wavegen_timer16
  import wgt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [CNT_BYTES-1:0] cnt_we,
  input  logic [CNT_W-1:0]     reg_wdata,
  input  logic                 cmp_a_we,
  input  logic                 cmp_b_we,
  input  logic                 cap_we,
  input  logic [MODE_W-1:0]    mode,
  input  logic [1:0]           out_mode_a,
  input  logic [1:0]           out_mode_b,
  input  logic                 force_a,
  input  logic                 force_b,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 wave_a,
  output logic                 wave_b,
  output logic                 wave_oe_a,
  output logic                 wave_oe_b,
  output logic                 ovf_flag,
  output logic                 match_flag_a,
  output logic                 match_flag_b
);
  fam_e fam;
  cnt_t top_val;
  logic up_q, adv, at_top, at_bot, ovf_evt;

  logic [NUM_CH-1:0] ch_we, ch_frc, ch_hit, ch_pin, ch_oe, ch_flag, ch_clr;
  logic [1:0]        ch_om [NUM_CH];
  cnt_t              ch_act [NUM_CH];

  assign ch_we    = {cmp_b_we, cmp_a_we};
  assign ch_frc   = {force_b, force_a};
  assign ch_clr   = flag_clr[NUM_FLAGS-1:1];
  assign ch_om[0] = out_mode_a;
  assign ch_om[1] = out_mode_b;

  wgt_top_select u_sel (
    .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .wdata(reg_wdata), .mode(mode),
    .cmp_a_act(ch_act[0]), .fam(fam), .top_val(top_val)
  );

  wgt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .wdata(reg_wdata),
    .fam(fam), .top_val(top_val), .cnt_q(cnt_q), .up_q(up_q), .adv(adv),
    .at_top(at_top), .at_bot(at_bot), .ovf_evt(ovf_evt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wgt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .fam(fam), .adv(adv), .at_top(at_top), .at_bot(at_bot),
      .up(up_q), .cnt(cnt_q), .cmp_we(ch_we[c]), .wdata(reg_wdata), .out_mode(ch_om[c]),
      .force_cmp(ch_frc[c]), .flag_clr(ch_clr[c]), .cmp_act(ch_act[c]), .hit(ch_hit[c]),
      .pin_q(ch_pin[c]), .oe(ch_oe[c]), .flag_q(ch_flag[c])
    );

    p_match_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[c] |=> ch_flag[c]);
    p_immediate_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fam_immediate(fam) && ch_we[c]) |=> (ch_act[c] == $past(reg_wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= (ovf_flag && !flag_clr[0]) || ovf_evt;
  end

  assign wave_a       = ch_pin[0];
  assign wave_b       = ch_pin[1];
  assign wave_oe_a    = ch_oe[0];
  assign wave_oe_b    = ch_oe[1];
  assign match_flag_a = ch_flag[0];
  assign match_flag_b = ch_flag[1];

  p_ovf_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ovf_evt));
  p_ovf_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !ovf_evt) |=> !ovf_flag);
  p_set_beats_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && ovf_evt) |=> ovf_flag);
endmodule

// File: tb/tb_wavegen_timer16.sv
`timescale 1ns/1ps
module tb_wavegen_timer16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tick = 0, cmp_a_we = 0, cmp_b_we = 0, cap_we = 0, frc_a = 0, frc_b = 0;
  logic [1:0]  cnt_we = 0, om_a = 0, om_b = 0;
  logic [15:0] reg_wdata = 0;
  logic [3:0]  mode = 0;
  logic [2:0]  flag_clr = 0;
  logic [15:0] cnt_q;
  logic        wave_a, wave_b, wave_oe_a, wave_oe_b, ovf_flag, match_flag_a, match_flag_b;

  wavegen_timer16 dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .reg_wdata(reg_wdata),
    .cmp_a_we(cmp_a_we), .cmp_b_we(cmp_b_we), .cap_we(cap_we), .mode(mode),
    .out_mode_a(om_a), .out_mode_b(om_b), .force_a(frc_a), .force_b(frc_b),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .wave_a(wave_a), .wave_b(wave_b),
    .wave_oe_a(wave_oe_a), .wave_oe_b(wave_oe_b), .ovf_flag(ovf_flag),
    .match_flag_a(match_flag_a), .match_flag_b(match_flag_b)
  );

  int n_chk = 0, n_bad = 0;
  logic [22:0] exp_q[$];
  string       tag_q[$];

  // Reference state, derived from the requirements
  logic [15:0] m_cnt = 0, m_bufa = 0, m_acta = 0, m_bufb = 0, m_actb = 0, m_per = 0;
  logic        m_up = 1, m_wa = 0, m_wb = 0;
  logic [2:0]  m_fl = 0;

  // 0 free, 1 clear-on-top, 2 single slope, 3 phase, 4 phase+freq, 5 reserved
  function automatic int kind_of(input logic [3:0] m);
    case (m)
      0: return 0;
      4, 12: return 1;
      5, 6, 7, 14, 15: return 2;
      8, 9: return 4;
      13: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic logic [15:0] top_of(input logic [3:0] m, input logic [15:0] a,
                                         input logic [15:0] p);
    case (m)
      0, 13: return 16'hFFFF;
      1, 5: return 16'h00FF;
      2, 6: return 16'h01FF;
      3, 7: return 16'h03FF;
      4, 9, 11, 15: return a;
      default: return p;
    endcase
  endfunction

  function automatic logic pin_of(input int k, input logic [1:0] om, input logic p,
                                  input logic m, input logic f, input logic et, input logic up);
    if (k == 5 || om == 0) return p;
    if (k <= 1) begin
      if (!(m || f)) return p;
      case (om)
        1: return !p;
        2: return 1'b0;
        default: return 1'b1;
      endcase
    end
    if (om == 1) return p;
    if (k == 2) return et ? !om[0] : (m ? om[0] : p);
    if (m) return up ? om[0] : !om[0];
    return p;
  endfunction

  task automatic cyc(input string tag);
    int k;
    logic [15:0] t, n;
    logic go, ma, mb, e_top, e_bot, ov, nu, pw, ld, oea, oeb;
    k = kind_of(mode);
    t = top_of(mode, m_acta, m_per);
    pw = (k >= 2 && k <= 4);
    go = tick && cnt_we == 2'b00 && k != 5;
    ma = go && m_cnt == m_acta;
    mb = go && m_cnt == m_actb;
    e_top = go && m_cnt == t;
    e_bot = go && m_cnt == 0;
    ov = (k <= 1) ? (go && m_cnt == 16'hFFFF) : (k == 2) ? e_top : (k <= 4) ? e_bot : 1'b0;
    ld = (k <= 1) ? 1'b1 : (k == 3) ? e_top : (k == 2 || k == 4) ? e_bot : 1'b0;
    n = m_cnt; nu = m_up;
    if (cnt_we[1]) n[15:8] = reg_wdata[15:8];
    if (cnt_we[0]) n[7:0] = reg_wdata[7:0];
    if (go) begin
      if (k == 0) begin n = m_cnt + 1; nu = 1; end
      else if (k <= 2) begin n = (m_cnt == t) ? 16'h0 : m_cnt + 1; nu = 1; end
      else if (m_up) begin
        if (m_cnt != t) n = m_cnt + 1;
        else if (t != 0) begin n = m_cnt - 1; nu = 0; end
      end else if (m_cnt == 0) begin n = 1; nu = 1; end
      else n = m_cnt - 1;
    end
    m_wa = pin_of(k, om_a, m_wa, ma, frc_a, e_top, m_up);
    m_wb = pin_of(k, om_b, m_wb, mb, frc_b, e_top, m_up);
    if (ld) begin
      m_acta = (k <= 1 && cmp_a_we) ? reg_wdata : m_bufa;
      m_actb = (k <= 1 && cmp_b_we) ? reg_wdata : m_bufb;
    end
    if (cmp_a_we) m_bufa = reg_wdata;
    if (cmp_b_we) m_bufb = reg_wdata;
    if (cap_we) m_per = reg_wdata;
    m_cnt = n; m_up = nu;
    m_fl = (m_fl & ~flag_clr) | {mb, ma, ov};
    oea = om_a != 0 && !(pw && om_a == 1);
    oeb = om_b != 0 && !(pw && om_b == 1);
    exp_q.push_back({m_cnt, m_wa, m_wb, oea, oeb, m_fl});
    tag_q.push_back(tag);
    @(negedge clk);
    cnt_we = 0; cmp_a_we = 0; cmp_b_we = 0; cap_we = 0; frc_a = 0; frc_b = 0; flag_clr = 0;
  endtask

  task automatic run(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) cyc(tag);
  endtask

  task automatic wr_cnt(input logic [15:0] v, input string tag);
    cnt_we = 2'b11; reg_wdata = v; cyc(tag);
  endtask

  // Monitor: pop one expected snapshot after each edge that the driver queued
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [22:0] e, a;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        a = {cnt_q, wave_a, wave_b, wave_oe_a, wave_oe_b, match_flag_b, match_flag_a, ovf_flag};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", tg, a, e);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({cnt_q, wave_a, wave_b, ovf_flag, match_flag_a, match_flag_b} !== 21'h0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h expected 0",
               {cnt_q, wave_a, wave_b, ovf_flag, match_flag_a, match_flag_b});
    end
    // R1: tick gating
    for (int i = 0; i < 8; i++) begin tick = i[0]; cyc("R1"); end
    // R2: byte writes beat tick
    tick = 1;
    cnt_we = 2'b10; reg_wdata = 16'h12AA; cyc("R2");
    cnt_we = 2'b01; reg_wdata = 16'hBB78; cyc("R2");
    wr_cnt(16'hFFFC, "R2");
    // R4: free-running wrap and overflow
    run(6, "R4");
    flag_clr = 3'b111; cyc("R12");
    wr_cnt(16'hFFFF, "R2");
    flag_clr = 3'b001; cyc("R12");
    flag_clr = 3'b111; cyc("R12");
    // R9 / R8: non-PWM pin actions
    cmp_a_we = 1; reg_wdata = 3; cyc("R7");
    cmp_b_we = 1; reg_wdata = 5; cyc("R7");
    om_a = 2'b01; om_b = 2'b11;
    wr_cnt(0, "R9");
    run(8, "R9");
    om_a = 2'b10;
    wr_cnt(0, "R9");
    run(6, "R8");
    // R10: force in non-PWM modes
    tick = 0; om_a = 2'b01; frc_a = 1; cyc("R10");
    om_b = 2'b10; frc_b = 1; cyc("R10");
    flag_clr = 3'b111; cyc("R12");
    mode = 4;
    wr_cnt(2, "R10");
    tick = 1; frc_a = 1; cyc("R10");
    run(3, "R10");
    // R4: clear-on-match modes
    wr_cnt(0, "R4");
    run(12, "R4");
    cap_we = 1; reg_wdata = 6; cyc("R3");
    mode = 12;
    run(16, "R4");
    wr_cnt(16'hFFFE, "R4");
    run(4, "R4");
    // R5 / R11: single slope
    mode = 5; om_a = 2'b10; om_b = 2'b11;
    wr_cnt(16'h00FC, "R5");
    run(8, "R5");
    mode = 14;
    wr_cnt(0, "R11");
    run(16, "R11");
    mode = 15;
    run(10, "R5");
    // R7: single-slope buffered update
    mode = 14;
    run(2, "R7");
    cmp_a_we = 1; reg_wdata = 1; cyc("R7");
    cmp_b_we = 1; reg_wdata = 6; cyc("R7");
    run(12, "R7");
    // R6 / R11: dual slope
    mode = 10;
    wr_cnt(0, "R6");
    run(16, "R6");
    run(14, "R11");
    mode = 1;
    wr_cnt(16'h00FC, "R6");
    run(10, "R6");
    // R7: phase correct loads at TOP, phase+freq at 0
    mode = 10;
    wr_cnt(0, "R7");
    run(3, "R7");
    cmp_b_we = 1; reg_wdata = 2; cyc("R7");
    run(14, "R7");
    mode = 8;
    cmp_b_we = 1; reg_wdata = 4; cyc("R7");
    cmp_a_we = 1; reg_wdata = 5; cyc("R7");
    run(16, "R7");
    // R10: force ignored in PWM; R11 output enable
    tick = 0; frc_a = 1; frc_b = 1; cyc("R10");
    om_a = 2'b01; cyc("R11");
    om_b = 2'b00; cyc("R11");
    // R13: reserved mode
    mode = 13; tick = 1; om_a = 2'b01;
    run(5, "R13");
    frc_a = 1; cyc("R13");
    // R3: fixed-resolution TOP values
    om_a = 2'b10; om_b = 2'b11;
    mode = 2; wr_cnt(16'h01FD, "R3"); run(6, "R3");
    mode = 7; wr_cnt(16'h03FD, "R3"); run(5, "R3");
    mode = 6; wr_cnt(16'h01FE, "R3"); run(3, "R3");
    mode = 3; wr_cnt(16'h03FE, "R3"); run(4, "R3");
    mode = 9; wr_cnt(0, "R3"); run(14, "R3");
    tick = 0;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule